// File: doc/BRIEF.md
# DDR Read Capture Point Trainer

This block sits on the host side of a double-data-rate read path. It chooses the sampling phase used to capture read data. The bench-facing inputs are a bank of phase-shifted sample taps, each giving one captured bit per IO lane on every clock. Before each read's data phase, the memory drives a known 8-bit learning sequence on every active lane for a short training window. During that window the block compares what every tap captured against the programmed expected sequence. A tap counts as good only when it reproduced the whole sequence without error on every active lane.

When the window ends, the block finds the longest unbroken stretch of good taps and picks the tap in its middle. It presents that tap with a valid flag for the rest of the read. If no tap was good, it keeps the tap chosen for the previous read and flags an error for this read. Training starts again from scratch on every window, so drift in voltage, temperature or board delay is followed from one read to the next.

Top module: `ddr_capture_trainer`

## Requirements
- R1: After reset, cap_tap is 0, and cap_valid and cap_err are both 0.
- R2: While preamble_win is high, each clock delivers one bit of the learning sequence, most significant bit first, starting with the first cycle of the window. Bit t*NLANES+l of tap_samples is the sample taken by tap t on lane l.
- R3: The expected sequence is taken from learn_pat, so any 8-bit value can be trained against (34h in typical use). A tap passes only if all 8 of its samples equal learn_pat on every active lane.
- R4: lane_mode selects the active lanes: 0 selects lane 0 only, 1 selects lanes 0 and 1, and 2 or 3 selects all four lanes. Samples on inactive lanes have no effect on the result.
- R5: The chosen tap is start + floor((len-1)/2), where start and len describe the longest contiguous run of passing taps.
- R6: When two or more runs share the longest length, the run with the lowest tap index is used.
- R7: The outputs change only at the clock edge where preamble_win is first sampled low after being high. On success, cap_valid=1 and cap_err=0 from that edge on.
- R8: If no tap passes, cap_tap keeps its previous value, cap_err=1 and cap_valid=0.
- R9: A window shorter than 8 cycles makes every tap fail. Samples taken after the 8th cycle of a window are ignored.
- R10: Between window closes, cap_tap, cap_valid and cap_err hold steady whatever the sample inputs do.
- R11: Each window is judged on its own samples only. A tap that failed in one read can pass in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, one pattern bit per cycle during the window |
| rst_n | input | 1 | Asynchronous active-low reset |
| preamble_win | input | 1 | High while the learning sequence is on the lanes |
| lane_mode | input | 2 | Active lane count: 0 = one, 1 = two, 2/3 = four |
| learn_pat | input | 8 | Expected learning sequence |
| tap_samples | input | NTAPS*NLANES (32) | Per-tap, per-lane sampled bits |
| cap_tap | output | TAP_W (3) | Selected capture tap |
| cap_valid | output | 1 | Last window produced a trained tap |
| cap_err | output | 1 | Last window found no passing tap |

## Verification
On every cycle, the assertions check four things. The outputs never move except at a window close. A close always leaves exactly one of valid and error set. A failed close keeps the tap. A window shorter than the pattern always ends in an error. Only the bench scenarios can show that the right tap is picked. These cover the midpoint of odd and even runs, the tie between equal runs, and masking of inactive lanes in each lane mode. They also cover a non-default pattern, and cycles beyond the eighth being ignored. The bench's per-cycle reference model compares each of these outcomes against an independent computation.

// File: rtl/ddr_cpt_pkg.sv
package ddr_cpt_pkg;
  typedef enum logic [1:0] {
    LM_ONE  = 2'd0,
    LM_TWO  = 2'd1,
    LM_FOUR = 2'd2
  } lane_mode_e;

  function automatic int active_lanes(input logic [1:0] mode, input int nlanes);
    int n;
    case (mode)
      2'd0:    n = 1;
      2'd1:    n = 2;
      default: n = 4;
    endcase
    if (n > nlanes) n = nlanes;
    return n;
  endfunction
endpackage

// File: rtl/cpt_tap_matcher.sv
module cpt_tap_matcher #(
  parameter int NLANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              first,
  input  logic              in_pat,
  input  logic              exp_bit,
  input  logic [NLANES-1:0] lane_bits,
  input  logic [NLANES-1:0] lane_mask,
  output logic              ok
);
  logic ok_q, ok_d, lanes_hit;

  assign lanes_hit = ((lane_bits ^ {NLANES{exp_bit}}) & lane_mask) == '0;

  always_comb begin
    ok_d = ok_q;
    if (samp_en) begin
      ok_d = (first ? 1'b1 : ok_q) & (in_pat ? lanes_hit : 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign ok = ok_q;
endmodule

// File: rtl/cpt_run_finder.sv
module cpt_run_finder #(
  parameter int NTAPS = 8,
  localparam int TAP_W = $clog2(NTAPS),
  localparam int LEN_W = $clog2(NTAPS + 1)
) (
  input  logic [NTAPS-1:0] pass_vec,
  output logic             any_pass,
  output logic [TAP_W-1:0] mid_tap
);
  logic [LEN_W-1:0] cur_len, best_len, half;
  logic [TAP_W-1:0] cur_start, best_start;

  always_comb begin
    cur_len    = '0;
    best_len   = '0;
    cur_start  = '0;
    best_start = '0;
    for (int t = 0; t < NTAPS; t++) begin
      if (pass_vec[t]) begin
        if (cur_len == '0) cur_start = TAP_W'(t);
        cur_len = cur_len + LEN_W'(1);
        if (cur_len > best_len) begin
          best_len   = cur_len;
          best_start = cur_start;
        end
      end else begin
        cur_len = '0;
      end
    end
    half     = (best_len - LEN_W'(1)) >> 1;
    any_pass = (best_len != '0);
    mid_tap  = best_start + half[TAP_W-1:0];
  end
endmodule

// File: rtl/ddr_capture_trainer.sv
module ddr_capture_trainer
  import ddr_cpt_pkg::*;
#(
  parameter int NTAPS  = 8,
  parameter int NLANES = 4,
  parameter int PAT_W  = 8,
  localparam int TAP_W = $clog2(NTAPS),
  localparam int CNT_W = $clog2(PAT_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    preamble_win,
  input  logic [1:0]              lane_mode,
  input  logic [PAT_W-1:0]        learn_pat,
  input  logic [NTAPS*NLANES-1:0] tap_samples,
  output logic [TAP_W-1:0]        cap_tap,
  output logic                    cap_valid,
  output logic                    cap_err
);
  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  // window tracking and bit index
  logic             win_q, first, close, in_pat, exp_bit, full;
  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic [PAT_W-1:0] pat_sh;

  assign first  = preamble_win & ~win_q;
  assign close  = win_q & ~preamble_win;
  assign idx    = first ? '0 : cnt_q;
  assign in_pat = idx < CNT_W'(PAT_W);
  assign pat_sh = learn_pat << idx;
  assign exp_bit = pat_sh[PAT_W-1];
  assign full   = cnt_q == CNT_W'(PAT_W);

  always_comb begin
    cnt_d = cnt_q;
    if (preamble_win && in_pat) cnt_d = idx + CNT_W'(1);
    else if (first)             cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      win_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      win_q <= preamble_win;
      cnt_q <= cnt_d;
    end
  end

  // active lane mask
  logic [NLANES-1:0] lane_mask;
  int act_n;
  assign act_n = active_lanes(lane_mode, NLANES);
  for (genvar l = 0; l < NLANES; l++) begin : g_mask
    assign lane_mask[l] = (l < act_n);
  end

  // one matcher per tap
  logic [NTAPS-1:0] ok_vec, pass_vec;
  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    cpt_tap_matcher #(.NLANES(NLANES)) u_match (
      .clk       (clk),
      .rst_n     (rs_n),
      .samp_en   (preamble_win),
      .first     (first),
      .in_pat    (in_pat),
      .exp_bit   (exp_bit),
      .lane_bits (tap_samples[t*NLANES +: NLANES]),
      .lane_mask (lane_mask),
      .ok        (ok_vec[t])
    );
  end
  assign pass_vec = ok_vec & {NTAPS{full}};

  logic             any_pass;
  logic [TAP_W-1:0] mid_tap;
  cpt_run_finder #(.NTAPS(NTAPS)) u_runs (
    .pass_vec (pass_vec),
    .any_pass (any_pass),
    .mid_tap  (mid_tap)
  );

  // result registers, loaded only at window close
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             val_q, val_d, err_q, err_d;

  always_comb begin
    tap_d = tap_q;
    val_d = val_q;
    err_d = err_q;
    if (close) begin
      if (any_pass) tap_d = mid_tap;
      val_d = any_pass;
      err_d = ~any_pass;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      tap_q <= '0;
      val_q <= 1'b0;
      err_q <= 1'b0;
    end else if (close) begin
      tap_q <= tap_d;
      val_q <= val_d;
      err_q <= err_d;
    end
  end

  assign cap_tap   = tap_q;
  assign cap_valid = val_q;
  assign cap_err   = err_q;
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int NTAPS = 8,
  parameter int PAT_W = 8,
  localparam int TAP_W = $clog2(NTAPS),
  localparam int CNT_W = $clog2(PAT_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preamble_win,
  input logic [TAP_W-1:0] cap_tap,
  input logic             cap_valid,
  input logic             cap_err
);
  logic             win_d, close;
  logic [CNT_W-1:0] wlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_d <= 1'b0;
      wlen  <= '0;
    end else begin
      win_d <= preamble_win;
      if (preamble_win && !win_d)                    wlen <= CNT_W'(1);
      else if (preamble_win && wlen < CNT_W'(PAT_W)) wlen <= wlen + CNT_W'(1);
    end
  end
  assign close = win_d & ~preamble_win;

  AST_HOLD_BETWEEN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    !close |=> ($stable(cap_tap) && $stable(cap_valid) && $stable(cap_err))); // R10

  AST_CLOSE_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (cap_valid != cap_err)); // R7

  AST_FAIL_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (cap_err -> $stable(cap_tap))); // R8

  AST_SHORT_WINDOW_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (close && wlen < CNT_W'(PAT_W)) |=> cap_err); // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_valid && cap_err)); // R8
endmodule

bind ddr_capture_trainer cpt_checker #(.NTAPS(NTAPS), .PAT_W(PAT_W)) u_cpt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .preamble_win (preamble_win),
  .cap_tap      (cap_tap),
  .cap_valid    (cap_valid),
  .cap_err      (cap_err)
);

// File: tb/ddr_capture_trainer_bench.sv
module ddr_capture_trainer_bench;
  localparam int NT = 8;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          win = 1'b0;
  logic [1:0]    mode = 2'd2;
  logic [7:0]    pat = 8'h34;
  logic [NT*NL-1:0] samp = '0;
  logic [2:0]    tap;
  logic          val, err;

  always #5 clk = ~clk;

  ddr_capture_trainer u_ddr_capture_trainer (
    .clk(clk), .rst_n(rst_n), .preamble_win(win), .lane_mode(mode),
    .learn_pat(pat), .tap_samples(samp),
    .cap_tap(tap), .cap_valid(val), .cap_err(err)
  );

  int    vectors = 0;
  int    fails = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [NT*NL-1:0] q[$];
  int   m_tap = 0;
  bit   m_val = 0, m_err = 0, m_wq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tap = 0; m_val = 0; m_err = 0; m_wq = 0; q = {};
    end else begin
      if (m_wq && !win) begin
        int nact, best_len, best_st, cur_len, cur_st;
        nact = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        best_len = 0; best_st = 0; cur_len = 0; cur_st = 0;
        for (int t = 0; t < NT; t++) begin
          bit ok;
          ok = q.size() >= 8;
          if (ok)
            for (int k = 0; k < 8; k++)
              for (int l = 0; l < nact; l++)
                if (q[k][t*NL+l] != pat[7-k]) ok = 0;
          if (ok) begin
            if (cur_len == 0) cur_st = t;
            cur_len++;
            if (cur_len > best_len) begin best_len = cur_len; best_st = cur_st; end
          end else cur_len = 0;
        end
        if (best_len > 0) begin
          m_tap = best_st + (best_len - 1) / 2; m_val = 1; m_err = 0;
        end else begin
          m_val = 0; m_err = 1;
        end
      end
      if (win) begin
        if (!m_wq) q = {};
        q.push_back(samp);
      end
      m_wq = win;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (tap !== 3'(m_tap) || val !== m_val || err !== m_err) begin
        fails++;
        $display("FAIL %s model: tap=%0d val=%0b err=%0b expected tap=%0d val=%0b err=%0b",
                 cur_req, tap, val, err, m_tap, m_val, m_err);
      end
    end
  end

  task automatic check(string req, int act_tap, int exp_tap, bit act_v, bit exp_v, bit act_e, bit exp_e);
    vectors++;
    if (act_tap != exp_tap || act_v != exp_v || act_e != exp_e) begin
      fails++;
      $display("FAIL %s: tap=%0d val=%0b err=%0b expected tap=%0d val=%0b err=%0b",
               req, act_tap, act_v, act_e, exp_tap, exp_v, exp_e);
    end
  endtask

  // one training window; bad taps see bad_lane inverted, junk lanes always inverted
  task automatic window(logic [7:0] p, logic [1:0] m, logic [7:0] good,
                        int bad_lane, logic [3:0] junk, int len);
    pat = p; mode = m;
    for (int k = 0; k < len; k++) begin
      logic b;
      b = (k < 8) ? p[7-k] : k[0];
      win = 1'b1;
      for (int t = 0; t < NT; t++)
        for (int l = 0; l < NL; l++)
          samp[t*NL+l] = b ^ junk[l] ^ (!good[t] && l == bad_lane);
      @(negedge clk);
    end
    win = 1'b0;
    samp = 32'($urandom);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      samp = 32'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    #(2_000_000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    check("R1 reset", tap, 0, val, 0, err, 0);

    cur_req = "R2";
    window(8'h34, 2'd2, 8'b0111_1100, 0, 4'b0, 8);   // taps 2..6
    check("R2 R5 odd run", tap, 4, val, 1, err, 0);
    idle(5);

    cur_req = "R10";
    check("R10 held after idle noise", tap, 4, val, 1, err, 0);

    cur_req = "R5";
    window(8'h34, 2'd2, 8'b0001_1110, 3, 4'b0, 8);   // taps 1..4
    check("R5 even run", tap, 2, val, 1, err, 0);

    cur_req = "R6";
    window(8'h34, 2'd2, 8'b0011_0011, 2, 4'b0, 8);   // 0..1 and 4..5
    check("R6 tie lowest", tap, 0, val, 1, err, 0);

    cur_req = "R5";
    window(8'h34, 2'd2, 8'b1111_1001, 1, 4'b0, 8);   // 0 and 3..7
    check("R5 longest run", tap, 5, val, 1, err, 0);

    cur_req = "R8";
    window(8'h34, 2'd2, 8'b0000_0000, 0, 4'b0, 8);
    check("R8 none pass", tap, 5, val, 0, err, 1);

    cur_req = "R11";
    window(8'h34, 2'd2, 8'b1111_1111, 0, 4'b0, 8);
    check("R11 fresh window", tap, 3, val, 1, err, 0);

    cur_req = "R4";
    window(8'h34, 2'd0, 8'b0011_1111, 0, 4'b1110, 8); // one lane, others junk
    check("R4 one lane", tap, 2, val, 1, err, 0);
    window(8'h34, 2'd1, 8'b0111_1111, 1, 4'b1100, 8); // two lanes, lane1 bad on tap 7
    check("R4 two lanes", tap, 3, val, 1, err, 0);
    window(8'h34, 2'd2, 8'b1111_1111, 0, 4'b1000, 8); // lane3 junk in x4
    check("R4 four lanes junk", tap, 3, val, 0, err, 1);

    cur_req = "R3";
    window(8'hA5, 2'd2, 8'b1111_0000, 2, 4'b0, 8);    // taps 4..7
    check("R3 other pattern", tap, 5, val, 1, err, 0);
    pat = 8'h34;
    window(8'hA5, 2'd2, 8'b1111_1111, 0, 4'b0, 8);
    check("R3 pattern used", tap, 3, val, 1, err, 0);

    cur_req = "R9";
    window(8'h34, 2'd2, 8'b1111_1111, 0, 4'b0, 6);
    check("R9 short window", tap, 3, val, 0, err, 1);
    window(8'h34, 2'd2, 8'b0000_0011, 0, 4'b0, 11);
    check("R9 extra cycles ignored", tap, 0, val, 1, err, 0);

    cur_req = "R7";
    pat = 8'h34; mode = 2'd2; win = 1'b1;
    for (int k = 0; k < 8; k++) begin
      for (int t = 0; t < NT; t++)
        for (int l = 0; l < NL; l++) samp[t*NL+l] = pat[7-k] ^ (t < 4 && l == 0);
      @(negedge clk);
    end
    check("R7 before close", tap, 0, val, 1, err, 0);
    win = 1'b0;
    @(posedge clk); #1;
    check("R7 one clock after close", tap, 5, val, 1, err, 0);
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule